// File: doc/BRIEF.md
# Stream-to-Memory Channel with Status Writeback

This block moves one inbound byte stream into memory. Software loads a descriptor (a destination base address, an expected byte count and an interrupt enable) and pulses a start strobe. The channel then accepts stream beats and hands each one to a memory-write port as a single write beat. The write address advances by one data-bus width per beat, and the byte strobes follow the stream's byte-keep lanes.

The transfer ends in one of two ways. Either the programmed byte count is consumed, or the source marks a beat as the last one before that point. In both cases the channel records the number of bytes it actually wrote, the sideband user value carried by the final beat, and whether the end came early. These values form the descriptor's status fields. A sticky done flag is then raised, and an interrupt follows if it was enabled. Software reads the status and clears the done flag before it can start another transfer.

Control is a three-state machine. CH_IDLE goes to CH_RUN on an accepted start. CH_RUN goes to CH_DONE on the final accepted beat. CH_DONE goes back to CH_IDLE on a clear pulse. No other transitions exist.

Top module: `s2m_wb_channel`

## Requirements
- R1: After reset, wb_done, irq, s_tready and m_wvalid are all 0.
- R2: A start is accepted only in CH_IDLE with a nonzero cfg_len. A start with cfg_len of 0, or a start while wb_done is set, leaves s_tready at 0 and wb_done and wb_len unchanged.
- R3: In CH_RUN, s_tready equals m_wready and m_wvalid equals s_tvalid. The k-th accepted beat (k from 0) is written at cfg_addr + k*4 bytes with m_wdata equal to s_tdata. Outside CH_RUN, s_tready is 0.
- R4: s_tkeep is contiguous from bit 0, and bit i covers data byte i. m_wstrb bit i is s_tkeep bit i ANDed with (remaining bytes > i). The bytes counted for a beat are the ones in m_wstrb.
- R5: If a beat carrying s_tlast is accepted while bytes remain after it, the transfer ends. wb_len becomes the byte total written, wb_early becomes 1, and s_tready stays 0 afterwards.
- R6: When the remaining count reaches zero on a beat without s_tlast, the transfer ends with wb_len equal to cfg_len and wb_early equal to 0. No further beats are accepted.
- R7: wb_user holds the s_tuser value of the final accepted beat.
- R8: wb_done rises in the cycle after the final beat and stays at 1 until a wb_clear pulse. The clear returns the channel to CH_IDLE.
- R9: irq is 1 exactly while wb_done is set, and only if cfg_irq_en was 1 at the accepted start.
- R10: If s_tlast and the size limit fall on the same beat, the result is a normal completion: wb_early is 0 and wb_len equals cfg_len.
- R11: cfg_len is 32 bits wide, so a length of 2^31 bytes is accepted. The byte total is tracked without loss at that size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Start pulse for the loaded descriptor |
| cfg_addr | input | ADDR_W | Destination base address |
| cfg_len | input | LEN_W | Expected byte count |
| cfg_irq_en | input | 1 | Raise irq on completion |
| wb_clear | input | 1 | Clears the done flag |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted |
| s_tdata | input | DATA_W | Stream data |
| s_tkeep | input | DATA_W/8 | Stream byte-keep lanes |
| s_tlast | input | 1 | Final beat of the stream packet |
| s_tuser | input | USER_W | Stream sideband value |
| m_wvalid | output | 1 | Memory write beat valid |
| m_wready | input | 1 | Memory accepts the write beat |
| m_waddr | output | ADDR_W | Write beat address |
| m_wdata | output | DATA_W | Write beat data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| wb_done | output | 1 | Status: transfer complete (sticky) |
| wb_len | output | LEN_W | Status: bytes actually written |
| wb_user | output | USER_W | Status: sideband value of the final beat |
| wb_early | output | 1 | Status: ended by s_tlast before the size limit |
| irq | output | 1 | Completion interrupt request |

## Verification
Two end conditions can fall on the same beat: the source's last-beat marker and the exhaustion of the programmed byte count. The bench sweeps every short length against every position of the marker and every partial keep width on the marked beat. This includes the cases where the marker lands exactly on the beat that consumes the last remaining byte, and where a partial keep on that beat still reaches the limit. For every case the bench works out arithmetically which condition wins, along with the expected length, flag and strobes. The coincident cases must report a normal completion with the programmed length. Each case runs with and without memory-side backpressure.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } ch_state_t;
endpackage

// File: rtl/s2m_beat_size.sv
// Clips the keep lanes of one beat to the bytes still owed and counts them.
module s2m_beat_size #(
    parameter int BPB   = 4,
    parameter int LEN_W = 32,
    localparam int CNT_W = $clog2(BPB + 1)
) (
    input  logic [BPB-1:0]   keep,
    input  logic [LEN_W-1:0] remain,
    output logic [BPB-1:0]   strb,
    output logic [CNT_W-1:0] nbytes,
    output logic             fills
);
    for (genvar i = 0; i < BPB; i++) begin : g_lane
        assign strb[i] = keep[i] && (remain > LEN_W'(i));
    end

    always_comb begin
        nbytes = '0;
        for (int j = 0; j < BPB; j++) begin
            nbytes = nbytes + CNT_W'(strb[j]);
        end
    end

    assign fills = (LEN_W'(nbytes) == remain);
endmodule

// File: rtl/s2m_ctrl.sv
// Channel sequencer: idle, running, done-and-waiting-for-clear.
module s2m_ctrl
    import s2m_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      len_nz,
    input  logic      fin,
    input  logic      clear,
    output logic      go,
    output logic      running,
    output logic      done
);
    ch_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (start && len_nz) state_nx = CH_RUN;
            CH_RUN:  if (fin)             state_nx = CH_DONE;
            CH_DONE: if (clear)           state_nx = CH_IDLE;
            default:                      state_nx = CH_IDLE;
        endcase
    end

    always_comb begin
        go      = 1'b0;
        running = 1'b0;
        done    = 1'b0;
        unique case (state)
            CH_IDLE: go      = start && len_nz;
            CH_RUN:  running = 1'b1;
            CH_DONE: done    = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/s2m_track.sv
// Address, remaining/written byte counters and the descriptor status fields.
module s2m_track #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32,
    parameter int USER_W = 4,
    parameter int BPB    = 4,
    localparam int CNT_W = $clog2(BPB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic              ien_in,
    input  logic              beat,
    input  logic              fin,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              fills,
    input  logic              last,
    input  logic [USER_W-1:0] user,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  remain,
    output logic              ien,
    output logic [LEN_W-1:0]  st_len,
    output logic [USER_W-1:0] st_user,
    output logic              st_early
);
    logic [LEN_W-1:0] written;
    logic [LEN_W-1:0] written_nx;

    assign written_nx = written + LEN_W'(nbytes);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr    <= '0;
            remain  <= '0;
            written <= '0;
            ien     <= 1'b0;
        end else if (go) begin
            addr    <= base;
            remain  <= len;
            written <= '0;
            ien     <= ien_in;
        end else if (beat) begin
            addr    <= addr + ADDR_W'(BPB);
            remain  <= remain - LEN_W'(nbytes);
            written <= written_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_len   <= '0;
            st_user  <= '0;
            st_early <= 1'b0;
        end else if (fin) begin
            st_len   <= written_nx;
            st_user  <= user;
            st_early <= last && !fills;
        end
    end
endmodule

// File: rtl/s2m_wb_channel.sv
module s2m_wb_channel #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 32,
    parameter int USER_W = 4,
    localparam int BPB   = DATA_W / 8,
    localparam int CNT_W = $clog2(BPB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_irq_en,
    input  logic              wb_clear,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [BPB-1:0]    s_tkeep,
    input  logic              s_tlast,
    input  logic [USER_W-1:0] s_tuser,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [ADDR_W-1:0] m_waddr,
    output logic [DATA_W-1:0] m_wdata,
    output logic [BPB-1:0]    m_wstrb,
    output logic              wb_done,
    output logic [LEN_W-1:0]  wb_len,
    output logic [USER_W-1:0] wb_user,
    output logic              wb_early,
    output logic              irq
);
    logic             go, running, done;
    logic             beat, fin, fills;
    logic [CNT_W-1:0] nbytes;
    logic [LEN_W-1:0] remain;
    logic             ien;

    assign s_tready = running && m_wready;
    assign m_wvalid = running && s_tvalid;
    assign m_wdata  = s_tdata;
    assign beat     = s_tvalid && s_tready;
    assign fin      = beat && (s_tlast || fills);
    assign wb_done  = done;
    assign irq      = done && ien;

    s2m_beat_size #(.BPB(BPB), .LEN_W(LEN_W)) u_size (
        .keep   (s_tkeep),
        .remain (remain),
        .strb   (m_wstrb),
        .nbytes (nbytes),
        .fills  (fills)
    );

    s2m_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cfg_start),
        .len_nz  (cfg_len != '0),
        .fin     (fin),
        .clear   (wb_clear),
        .go      (go),
        .running (running),
        .done    (done)
    );

    s2m_track #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .USER_W(USER_W), .BPB(BPB)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .base     (cfg_addr),
        .len      (cfg_len),
        .ien_in   (cfg_irq_en),
        .beat     (beat),
        .fin      (fin),
        .nbytes   (nbytes),
        .fills    (fills),
        .last     (s_tlast),
        .user     (s_tuser),
        .addr     (m_waddr),
        .remain   (remain),
        .ien      (ien),
        .st_len   (wb_len),
        .st_user  (wb_user),
        .st_early (wb_early)
    );
endmodule

// File: rtl/s2m_wb_channel_chk.sv
module s2m_wb_channel_chk #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 32,
    localparam int BPB   = DATA_W / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_start,
    input logic             wb_clear,
    input logic             s_tvalid,
    input logic             s_tready,
    input logic [BPB-1:0]   s_tkeep,
    input logic             m_wvalid,
    input logic             m_wready,
    input logic [BPB-1:0]   m_wstrb,
    input logic             wb_done,
    input logic [LEN_W-1:0] wb_len,
    input logic             irq
);
    // R3
    no_ready_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done |-> !s_tready);
    // R3
    ready_follows_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready |-> m_wready);
    // R3
    write_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid |-> s_tvalid);
    // R4
    strobe_in_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid |-> ((m_wstrb & ~s_tkeep) == '0));
    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_done && !wb_clear) |=> wb_done);
    // R2
    start_while_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_done && cfg_start && !wb_clear) |=> (wb_done && $stable(wb_len)));
    // R9
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wb_done);
endmodule

bind s2m_wb_channel s2m_wb_channel_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_start (cfg_start),
    .wb_clear  (wb_clear),
    .s_tvalid  (s_tvalid),
    .s_tready  (s_tready),
    .s_tkeep   (s_tkeep),
    .m_wvalid  (m_wvalid),
    .m_wready  (m_wready),
    .m_wstrb   (m_wstrb),
    .wb_done   (wb_done),
    .wb_len    (wb_len),
    .irq       (irq)
);

// File: tb/s2m_wb_channel_test.sv
module s2m_wb_channel_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 32;
    localparam int UW = 4;
    localparam int BPB = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_start = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [LW-1:0] cfg_len = '0;
    logic          cfg_irq_en = 1'b0;
    logic          wb_clear = 1'b0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic [DW-1:0] s_tdata = '0;
    logic [BPB-1:0] s_tkeep = '0;
    logic          s_tlast = 1'b0;
    logic [UW-1:0] s_tuser = '0;
    logic          m_wvalid;
    logic          m_wready = 1'b0;
    logic [AW-1:0] m_waddr;
    logic [DW-1:0] m_wdata;
    logic [BPB-1:0] m_wstrb;
    logic          wb_done;
    logic [LW-1:0] wb_len;
    logic [UW-1:0] wb_user;
    logic          wb_early;
    logic          irq;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    s2m_wb_channel uut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_addr(cfg_addr),
        .cfg_len(cfg_len), .cfg_irq_en(cfg_irq_en), .wb_clear(wb_clear),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .s_tkeep(s_tkeep), .s_tlast(s_tlast), .s_tuser(s_tuser),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_waddr(m_waddr),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .wb_done(wb_done),
        .wb_len(wb_len), .wb_user(wb_user), .wb_early(wb_early), .irq(irq)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_start(logic [LW-1:0] len, logic [AW-1:0] base, logic ien);
        @(negedge clk);
        cfg_len = len; cfg_addr = base; cfg_irq_en = ien; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        wb_clear = 1'b1;
        @(negedge clk);
        wb_clear = 1'b0;
        #1;
        chk("R8", "done after clear", wb_done, 0);
        chk("R9", "irq after clear", irq, 0);
    endtask

    // tb: index of the beat with s_tlast (0 = none); k: keep width on that beat.
    task automatic run_case(logic [LW-1:0] len, int tb, int k, bit bp, bit ien, bit clear_after);
        logic [AW-1:0] base;
        logic [LW-1:0] rem;
        logic [LW-1:0] cnt;
        logic [UW-1:0] exp_user;
        bit exp_early;
        bit fin_m;
        bit tl;
        int b;
        int cyc;
        string tag;
        base = 32'h1000 + len * 64;
        rem = len; cnt = 0; b = 0; cyc = 0; fin_m = 0; exp_early = 0; exp_user = '0;
        tl = 0;
        do_start(len, base, ien);
        while (!fin_m) begin
            logic [BPB-1:0] kb;
            logic [BPB-1:0] es;
            int nb;
            bit acc;
            int wait_n;
            kb = (b + 1 == tb) ? BPB'((1 << k) - 1) : '1;
            es = '0; nb = 0;
            for (int i = 0; i < BPB; i++) begin
                es[i] = kb[i] && (rem > LW'(i));
                nb += int'(es[i]);
            end
            tl = (b + 1 == tb);
            s_tvalid = 1'b1; s_tkeep = kb; s_tlast = tl;
            s_tuser = UW'((b * 3 + int'(len)) % 16);
            s_tdata = 32'hA000_0000 | (len[15:0] << 8) | b;
            acc = 0; wait_n = 0;
            while (!acc) begin
                m_wready = bp ? (cyc % 3 != 2) : 1'b1;
                cyc++;
                #1;
                if (s_tready) begin
                    acc = 1;
                    chk("R3", "write address", m_waddr, base + b * BPB);
                    chk("R3", "write data", m_wdata, s_tdata);
                    chk("R4", "write strobe", m_wstrb, es);
                end else begin
                    chk("R3", "stalled beat not written", s_tready, m_wready ? 1 : 0);
                end
                @(negedge clk);
                wait_n++;
                if (wait_n > 20) begin
                    chk("R3", "beat never accepted", 0, 1);
                    acc = 1; fin_m = 1;
                end
            end
            b++;
            cnt += LW'(nb); rem -= LW'(nb);
            if (tl || rem == 0) begin
                fin_m = 1;
                exp_early = tl && (rem != 0);
                exp_user = s_tuser;
            end
        end
        if (len >= 32'h8000_0000) tag = "R11";
        else if (tl && rem == 0) tag = "R10";
        else if (exp_early) tag = "R5";
        else tag = "R6";
        // offer one more beat; the finished channel must refuse it
        s_tlast = 1'b0; s_tkeep = '1; m_wready = 1'b1;
        #1;
        chk(tag, "no beat after end", s_tready, 0);
        chk("R8", "done raised", wb_done, 1);
        chk(tag, "written length", wb_len, cnt);
        chk(tag, "early flag", wb_early, exp_early);
        chk("R7", "captured user", wb_user, exp_user);
        chk("R9", "irq level", irq, ien);
        s_tvalid = 1'b0;
        if (clear_after) do_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [LW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_wready = 1'b1;
        #1;
        chk("R1", "done at reset", wb_done, 0);
        chk("R1", "irq at reset", irq, 0);
        chk("R1", "tready at reset", s_tready, 0);
        chk("R1", "wvalid at reset", m_wvalid, 0);

        // zero length start is ignored
        do_start(0, 32'h40, 1'b1);
        s_tvalid = 1'b1; m_wready = 1'b1;
        #1;
        chk("R2", "zero length tready", s_tready, 0);
        @(negedge clk);
        chk("R2", "zero length done", wb_done, 0);
        s_tvalid = 1'b0;

        // sweep length, tlast position, keep width, backpressure
        for (int len = 1; len <= 9; len++)
            for (int tb = 0; tb <= 4; tb++)
                for (int k = 1; k <= BPB; k++)
                    for (int bp = 0; bp < 2; bp++)
                        if (tb != 0 || k == BPB)
                            run_case(LW'(len), tb, k, bit'(bp), bit'((len + tb) % 2), 1'b1);

        // start while done is ignored
        run_case(LW'(6), 0, BPB, 1'b0, 1'b1, 1'b0);
        held = wb_len;
        do_start(LW'(11), 32'h2000, 1'b0);
        s_tvalid = 1'b1; m_wready = 1'b1;
        #1;
        chk("R2", "start while done tready", s_tready, 0);
        chk("R2", "start while done length", wb_len, held);
        chk("R2", "start while done flag", wb_done, 1);
        s_tvalid = 1'b0;
        do_clear();

        // largest length, ended early by tlast on the third full beat
        run_case(32'h8000_0000, 3, BPB, 1'b0, 1'b1, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule